// File: doc/BRIEF.md
# GPS Integrate-and-Dump Correlator Channel

This block is one tracking channel of a GPS baseband receiver. Every clock of the radio front end (nominally 16.368 MHz) it takes a one-bit sign sample. It mixes that sample with in-phase and quadrature carrier signs taken from a local 32-bit phase accumulator, and then with a spreading-code replica bit supplied from outside. The two products are summed over one code repetition period. At the default setting that period is 16368 samples, or 1 ms.

At each period boundary the two sums are captured into a holding register and the integrators restart in the same cycle, so every sample counts exactly once. A ready flag then tells the control processor that new results exist. The processor starts a read, which clears the flag, and then clocks the 32 result bits out of a single serial pin, one bit per strobe. The processor also writes the carrier frequency word. A new word is held pending and is applied at the next period boundary, so each dump uses a single frequency.

Each integrator is 16 bits wide with one extra half-unit bit. The reported value is the half-sum in offset binary, which the processor can treat directly as an unsigned 16-bit number.

Top module: `gps_corr_channel`

## Requirements
- R1: After reset, `dump_rdy` is 0, `sdo` is 0, the active and pending carrier frequency words are 0, and the carrier phase is 0.
- R2: A sample or code bit of 1 means -1 and a bit of 0 means +1. For each arm, the product of sample, code and carrier is -1 exactly when the XOR of the three sign bits is 1.
- R3: The carrier phase starts at 0 and advances by the active frequency word on every sample, modulo 2^32. With phase bits [31] and [30], the in-phase carrier sign is [31] XOR [30] and the quadrature carrier sign is [31].
- R4: A dump occurs on every DUMP_LEN-th sample (default 16368). The first dump covers the first DUMP_LEN samples after reset, and each later dump covers exactly the next DUMP_LEN samples.
- R5: Each result equals 0x8000 + floor(S/2) as an unsigned 16-bit value, where S is the arm's signed sum of the +1/-1 products over the period. An extra half-unit bit keeps odd sums exact inside the period. A full 16368-sample period of all +1 gives 0x9FF8, and a full period of all -1 gives 0x6008.
- R6: `dump_rdy` is 1 from the cycle after a dump. It returns to 0 in the cycle after `rd_start`, unless a dump occurs in the same cycle, in which case the flag stays set.
- R7: `rd_start` loads the latched pair onto the serial path. After that, `sdo` shows the I word and then the Q word, most significant bit first. Each `rd_shift` advances one bit. When neither `rd_start` nor `rd_shift` is asserted, `sdo` holds its value.
- R8: A write of `frq_word` with `frq_wr` becomes pending immediately and becomes active only at the next dump boundary. The samples of the period in which the write occurs still use the previous word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Front-end sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_sign | input | 1 | Front-end sample sign bit (1 = -1) |
| code_sign | input | 1 | Spreading-code replica bit (1 = -1) |
| frq_wr | input | 1 | Carrier frequency word write strobe |
| frq_word | input | 32 | Carrier phase increment per sample |
| rd_start | input | 1 | Start of a serial read; loads the latched results |
| rd_shift | input | 1 | Advance the serial output by one bit |
| sdo | output | 1 | Serial result bit |
| dump_rdy | output | 1 | New results latched and not yet read |

## Verification
A wrong phase or a wrong frequency-switch moment does not stop the block. It only distorts the I/Q pair of the period concerned, and that shows at the first read after the affected dump. A sample count that is off by one shifts the boundary and changes every result from the first dump on. A lost or doubled half-unit bit moves a result by one count. A ready flag or serial register that is out of step shows within one cycle of a read strobe, as a flag that stays set or as a misordered bit.

// File: rtl/gps_corr_pkg.sv
package gps_corr_pkg;

    localparam int ACC_W   = 16;
    localparam int PHASE_W = 32;
    localparam int ARMS    = 2;
    localparam int RES_W   = ACC_W * ARMS;

    // Integrator: offset-binary half-sum plus the half-unit bit
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             half;
    } integ_t;

    // Carrier phase accumulator with pending/active frequency words
    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic [PHASE_W-1:0] pend;
        logic [PHASE_W-1:0] act;
    } nco_t;

    // Result holding and serial readout
    typedef struct packed {
        logic [RES_W-1:0] hold;
        logic [RES_W-1:0] shreg;
        logic             rdy;
    } rdo_t;

endpackage

// File: rtl/carrier_nco.sv
module carrier_nco
    import gps_corr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [PHASE_W-1:0] wr_word,
    input  logic               dump,
    output logic               i_neg,
    output logic               q_neg,
    output logic [PHASE_W-1:0] freq_act
);

    nco_t nco_d, nco_q;

    always_comb begin
        nco_d       = nco_q;
        nco_d.phase = nco_q.phase + nco_q.act;
        if (wr_en) begin
            nco_d.pend = wr_word;
        end
        if (dump) begin
            nco_d.act = nco_q.pend;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nco_q <= '0;
        end else begin
            nco_q <= nco_d;
        end
    end

    assign i_neg    = nco_q.phase[PHASE_W-1] ^ nco_q.phase[PHASE_W-2];
    assign q_neg    = nco_q.phase[PHASE_W-1];
    assign freq_act = nco_q.act;

endmodule

// File: rtl/corr_integrator.sv
module corr_integrator
    import gps_corr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prod_neg,
    input  logic             dump,
    output logic [ACC_W-1:0] dump_val
);

    localparam logic [ACC_W-1:0] BIAS = ACC_W'(1) << (ACC_W - 1);

    integ_t int_d, int_q, step;

    always_comb begin
        step = int_q;
        if (!prod_neg) begin
            if (int_q.half) begin
                step.acc  = int_q.acc + ACC_W'(1);
                step.half = 1'b0;
            end else begin
                step.half = 1'b1;
            end
        end else begin
            if (int_q.half) begin
                step.half = 1'b0;
            end else begin
                step.acc  = int_q.acc - ACC_W'(1);
                step.half = 1'b1;
            end
        end
        if (dump) begin
            int_d.acc  = BIAS;
            int_d.half = 1'b0;
        end else begin
            int_d = step;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_q.acc  <= BIAS;
            int_q.half <= 1'b0;
        end else begin
            int_q <= int_d;
        end
    end

    assign dump_val = step.acc;

endmodule

// File: rtl/dump_readout.sv
module dump_readout
    import gps_corr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dump,
    input  logic [RES_W-1:0] dump_pair,
    input  logic             rd_start,
    input  logic             rd_shift,
    output logic             sdo,
    output logic             rdy
);

    rdo_t rdo_d, rdo_q;

    always_comb begin
        rdo_d = rdo_q;
        if (rd_start) begin
            rdo_d.shreg = rdo_q.hold;
            rdo_d.rdy   = 1'b0;
        end else if (rd_shift) begin
            rdo_d.shreg = {rdo_q.shreg[RES_W-2:0], 1'b0};
        end
        if (dump) begin
            rdo_d.hold = dump_pair;
            rdo_d.rdy  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdo_q <= '0;
        end else begin
            rdo_q <= rdo_d;
        end
    end

    assign sdo = rdo_q.shreg[RES_W-1];
    assign rdy = rdo_q.rdy;

endmodule

// File: rtl/gps_corr_channel.sv
module gps_corr_channel
    import gps_corr_pkg::*;
#(
    parameter int DUMP_LEN = 16368
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_sign,
    input  logic               code_sign,
    input  logic               frq_wr,
    input  logic [PHASE_W-1:0] frq_word,
    input  logic               rd_start,
    input  logic               rd_shift,
    output logic               sdo,
    output logic               dump_rdy
);

    localparam int CNT_W = $clog2(DUMP_LEN);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DUMP_LEN - 1);

    logic [CNT_W-1:0]   cnt_d, cnt_q;
    logic               dump;
    logic               i_neg, q_neg;
    logic [PHASE_W-1:0] freq_act;
    logic [ARMS-1:0]    prod_neg;
    logic [ACC_W-1:0]   arm_val [ARMS];
    logic [RES_W-1:0]   dump_pair;

    always_comb begin
        cnt_d = cnt_q + CNT_W'(1);
        if (cnt_q == LAST) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign dump = (cnt_q == LAST);

    carrier_nco u_nco (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (frq_wr),
        .wr_word  (frq_word),
        .dump     (dump),
        .i_neg    (i_neg),
        .q_neg    (q_neg),
        .freq_act (freq_act)
    );

    assign prod_neg[0] = smp_sign ^ code_sign ^ i_neg;
    assign prod_neg[1] = smp_sign ^ code_sign ^ q_neg;

    for (genvar a = 0; a < ARMS; a++) begin : g_arm
        corr_integrator u_int (
            .clk      (clk),
            .rst_n    (rst_n),
            .prod_neg (prod_neg[a]),
            .dump     (dump),
            .dump_val (arm_val[a])
        );
        // arm 0 (I) lands in the upper word so it leaves first
        assign dump_pair[RES_W-1-a*ACC_W -: ACC_W] = arm_val[a];
    end

    dump_readout u_rdo (
        .clk       (clk),
        .rst_n     (rst_n),
        .dump      (dump),
        .dump_pair (dump_pair),
        .rd_start  (rd_start),
        .rd_shift  (rd_shift),
        .sdo       (sdo),
        .rdy       (dump_rdy)
    );

endmodule

// File: rtl/gps_corr_chk.sv
module gps_corr_chk #(
    parameter int DUMP_LEN = 16368,
    parameter int CNT_W    = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dump,
    input logic             rd_start,
    input logic             rd_shift,
    input logic             dump_rdy,
    input logic             sdo,
    input logic [31:0]      freq_act,
    input logic [CNT_W-1:0] cnt_q
);

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(DUMP_LEN));

    // R6
    rdy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dump |=> dump_rdy);

    // R6
    rdy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && !dump) |=> !dump_rdy);

    // R7
    sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_start && !rd_shift) |=> $stable(sdo));

    // R8
    freq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dump |=> $stable(freq_act));

endmodule

bind gps_corr_channel gps_corr_chk #(
    .DUMP_LEN (DUMP_LEN),
    .CNT_W    (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dump     (dump),
    .rd_start (rd_start),
    .rd_shift (rd_shift),
    .dump_rdy (dump_rdy),
    .sdo      (sdo),
    .freq_act (freq_act),
    .cnt_q    (cnt_q)
);

// File: tb/test_gps_corr_channel.sv
module test_gps_corr_channel;

    localparam int N      = 16368;
    localparam int NDUMPS = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_sign = 1'b0;
    logic        code_sign = 1'b0;
    logic        frq_wr = 1'b0;
    logic [31:0] frq_word = '0;
    logic        rd_start = 1'b0;
    logic        rd_shift = 1'b0;
    logic        sdo;
    logic        dump_rdy;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];

    always #2.5 clk = ~clk;

    gps_corr_channel i_gps_corr_channel (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_sign  (smp_sign),
        .code_sign (code_sign),
        .frq_wr    (frq_wr),
        .frq_word  (frq_word),
        .rd_start  (rd_start),
        .rd_shift  (rd_shift),
        .sdo       (sdo),
        .dump_rdy  (dump_rdy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver with reference model (R2, R3, R4, R5, R8)
    task automatic drive_all();
        logic [31:0] ph    = '0;
        logic [31:0] fact  = '0;
        logic [31:0] fpend = '0;
        int si = 0;
        int sq = 0;
        for (int p = 0; p < NDUMPS; p++) begin
            int wr_at = (p == 1) ? 200 : (p == 2) ? N - 30 : (p >= 3) ? 17 + p * 311 : -1;
            for (int k = 0; k < N; k++) begin
                logic s, c, pi, pq, ineg, qneg;
                case (p)
                    0: begin s = 1'b0; c = 1'b0; end
                    1: begin s = 1'b1; c = 1'b0; end
                    default: begin s = 1'($urandom); c = 1'($urandom); end
                endcase
                smp_sign  = s;
                code_sign = c;
                frq_wr    = (k == wr_at);
                frq_word  = (p == 1) ? 32'h4000_0000 : $urandom;
                ineg = ph[31] ^ ph[30];
                qneg = ph[31];
                pi = s ^ c ^ ineg;
                pq = s ^ c ^ qneg;
                si += pi ? -1 : 1;
                sq += pq ? -1 : 1;
                ph = ph + fact;
                if (k == N - 1) begin
                    logic [15:0] ei, eq;
                    ei = 16'(32'sh8000 + (si >>> 1));
                    eq = 16'(32'sh8000 + (sq >>> 1));
                    exp_q.push_back({ei, eq});
                    si = 0;
                    sq = 0;
                    fact = fpend;
                end
                if (frq_wr) fpend = frq_word;
                @(negedge clk);
            end
        end
        frq_wr = 1'b0;
        smp_sign = 1'b0;
        code_sign = 1'b0;
    endtask

    // Monitor: read each dump serially and compare (R5, R6, R7)
    task automatic monitor_all();
        for (int d = 0; d < NDUMPS; d++) begin
            logic [31:0] got, exp;
            while (!dump_rdy) @(negedge clk);
            rd_start = 1'b1;
            @(negedge clk);
            rd_start = 1'b0;
            check("R6 ready cleared by read start", {31'b0, dump_rdy}, 32'd0);
            for (int b = 31; b >= 0; b--) begin
                got[b] = sdo;
                rd_shift = (b != 0);
                @(negedge clk);
            end
            rd_shift = 1'b0;
            exp = exp_q.pop_front();
            check($sformatf("R5 R7 I word dump %0d", d), {16'b0, got[31:16]}, {16'b0, exp[31:16]});
            check($sformatf("R5 R7 Q word dump %0d", d), {16'b0, got[15:0]}, {16'b0, exp[15:0]});
            if (d == 0) check("R5 full +1 period I", {16'b0, got[31:16]}, 32'h9FF8);
            if (d == 1) check("R5 full -1 period Q", {16'b0, got[15:0]}, 32'h6008);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1
        check("R1 dump_rdy after reset", {31'b0, dump_rdy}, 32'd0);
        check("R1 sdo after reset", {31'b0, sdo}, 32'd0);
        rst_n = 1'b1;
        fork
            drive_all();
            monitor_all();
        join
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule